// File: doc/BRIEF.md
# Timestamp Readout Buffer

This block sits between a timestamp producer and a host register interface. Timestamps arrive as single beats on a valid/ready stream. Each beat carries a seconds count, a reference-cycle count and a fine phase value. Every accepted beat is tagged with a 16-bit sequence number and stored in a first-in first-out buffer.

The host reads the oldest entry as three 32-bit words through a simple read port. Read data appears one cycle after the request. Reading the word that carries the fine phase and the sequence number removes the entry, so the host reads seconds and cycles first and that word last. Reading the other two words leaves the buffer untouched.

Plain control inputs select the block's behaviour:
- a level input enables storing new timestamps;
- a one-cycle pulse discards every stored entry;
- a one-cycle pulse restarts the sequence numbering.

Status outputs report when the buffer is full and when it is empty. An interrupt line stays high for as long as at least one entry is waiting.

Stream rules: `in_ready` is high only when a beat offered in that cycle will be stored. The producer is not required to hold a beat while `in_ready` is low. Such a beat is discarded and does not consume a sequence number.

Top module: `ts_readout_buf`

## Requirements
- R1: After reset the buffer is empty: `buf_empty`=1, `buf_full`=0, `irq_pending`=0, `rd_valid`=0 and `rd_data`=0. The first stored entry gets sequence number 0.
- R2: A beat is stored at a clock edge exactly when `in_valid` and `in_ready` are both high. `in_ready` equals `enable` AND NOT `buf_full` AND NOT `purge`.
- R3: Each stored entry gets the current sequence number, and the number then grows by one. It wraps from 65535 to 0.
- R4: A read request (`rd_en` high, with `rd_addr`) returns data on `rd_data` with `rd_valid`=1 one cycle later. The addresses map as follows:
  - 0 returns the seconds value.
  - 1 returns the cycle count in bits 27:0, with bits 31:28 zero.
  - 2 returns the fine phase in bits 11:0, zero in bits 15:12 and the sequence number in bits 31:16.
  - 3 returns zero.
- R5: A read of address 2 while the buffer is not empty removes the oldest entry. Reads of addresses 0, 1 and 3 never remove an entry.
- R6: Entries are read out in the order they were stored.
- R7: With DEPTH entries stored (default 16), `buf_full`=1 and `in_ready`=0. Beats offered while full are not stored and do not advance the sequence number.
- R8: While `enable` is low no beat is stored and the sequence number does not advance.
- R9: A `purge` pulse leaves the buffer empty in the next cycle. A beat offered in the same cycle is discarded, and the sequence number is not reset.
- R10: A `seq_clear` pulse makes the next stored entry carry sequence number 0. If a beat is stored in the same cycle, that entry carries 0 and the following one carries 1.
- R11: `irq_pending` is high exactly while the buffer holds at least one entry.
- R12: Any read while the buffer is empty returns zero and leaves the buffer empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Level: allow new timestamps to be stored |
| purge | input | 1 | One-cycle pulse: discard all entries |
| seq_clear | input | 1 | One-cycle pulse: restart sequence numbering at 0 |
| in_valid | input | 1 | Timestamp beat offered |
| in_ready | output | 1 | The offered beat is stored this cycle |
| in_sec | input | 32 | Seconds value |
| in_cyc | input | 28 | Reference-cycle count |
| in_fine | input | 12 | Fine phase |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 2 | Word select for the read |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds the answer to last cycle's request |
| buf_full | output | 1 | Buffer holds DEPTH entries |
| buf_empty | output | 1 | Buffer holds no entries |
| irq_pending | output | 1 | Interrupt: at least one entry waiting |

## Verification
The assertions check the following on every cycle:
- the sequence counter steps by exactly one per stored beat, or returns to zero on a clear;
- the occupancy moves by one on a lone store or a lone removal;
- a purge always ends in the empty state;
- the stream never accepts while full;
- read answers arrive one cycle after the request, and reads of an empty buffer return zero;
- the interrupt follows emptiness.

Only the bench scenarios can show the remaining behaviour. This covers the payload itself and its first-in first-out order, and the exact sequence values seen after drops, purges and clears. It also covers the wrap from 65535 to 0 after a long run of stores, and the fact that reads of the seconds and cycle words do not remove an entry.

// File: rtl/ts_buf_pkg.sv
package ts_buf_pkg;
  localparam int SEC_W  = 32;
  localparam int CYC_W  = 28;
  localparam int FINE_W = 12;
  localparam int SEQ_W  = 16;
  localparam int WORD_W = 32;

  // word select codes on the read port
  localparam logic [1:0] WSEL_SEC  = 2'd0;
  localparam logic [1:0] WSEL_CYC  = 2'd1;
  localparam logic [1:0] WSEL_FSEQ = 2'd2;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [CYC_W-1:0]  cyc;
    logic [FINE_W-1:0] fine;
    logic [SEQ_W-1:0]  seq;
  } ts_entry_t;
endpackage

// File: rtl/ts_seq_counter.sv
module ts_seq_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] seq_now,
  output logic [W-1:0] seq_q
);
  logic [W-1:0] cnt_q;

  // a clear in the same cycle as a store gives that store number zero
  assign seq_now = clear ? '0 : cnt_q;
  assign seq_q   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (step)  cnt_q <= seq_now + 1'b1;
    else if (clear) cnt_q <= '0;
  end
endmodule

// File: rtl/ts_fifo_store.sv
module ts_fifo_store
  import ts_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  ts_entry_t        wdata,
  output ts_entry_t        head,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] fill
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  ts_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign fill  = cnt_q;
endmodule

// File: rtl/ts_read_port.sv
module ts_read_port
  import ts_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  input  ts_entry_t         head,
  input  logic              empty,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [WORD_W-1:0] word_sel;

  always_comb begin
    word_sel = '0;
    if (!empty) begin
      case (rd_addr)
        WSEL_SEC:  word_sel = WORD_W'(head.sec);
        WSEL_CYC:  word_sel = {{(WORD_W-CYC_W){1'b0}}, head.cyc};
        WSEL_FSEQ: word_sel = {head.seq, {(WORD_W-SEQ_W-FINE_W){1'b0}}, head.fine};
        default:   word_sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_sel;
    end
  end
endmodule

// File: rtl/ts_readout_buf.sv
module ts_readout_buf
  import ts_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              purge,
  input  logic              seq_clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEC_W-1:0]  in_sec,
  input  logic [CYC_W-1:0]  in_cyc,
  input  logic [FINE_W-1:0] in_fine,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              buf_full,
  output logic              buf_empty,
  output logic              irq_pending
);
  logic             push_w, pop_w;
  logic [SEQ_W-1:0] seq_now, seq_q;
  logic [CNT_W-1:0] fill_w;
  ts_entry_t        wr_entry, head;

  assign in_ready = enable & ~buf_full & ~purge;
  assign push_w   = in_valid & in_ready;
  assign pop_w    = rd_en & (rd_addr == WSEL_FSEQ) & ~buf_empty & ~purge;

  ts_seq_counter #(.W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(seq_clear), .step(push_w),
    .seq_now(seq_now), .seq_q(seq_q)
  );

  always_comb begin
    wr_entry.sec  = in_sec;
    wr_entry.cyc  = in_cyc;
    wr_entry.fine = in_fine;
    wr_entry.seq  = seq_now;
  end

  ts_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w), .flush(purge),
    .wdata(wr_entry), .head(head), .full(buf_full), .empty(buf_empty),
    .fill(fill_w)
  );

  ts_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .head(head), .empty(buf_empty), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign irq_pending = ~buf_empty;
endmodule

// File: rtl/ts_buf_checker.sv
module ts_buf_checker #(
  parameter int CNT_W = 5,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             purge,
  input logic             seq_clear,
  input logic             in_ready,
  input logic             rd_en,
  input logic [31:0]      rd_data,
  input logic             rd_valid,
  input logic             buf_full,
  input logic             buf_empty,
  input logic             irq_pending,
  input logic             push_w,
  input logic             pop_w,
  input logic [CNT_W-1:0] fill_w,
  input logic [SEQ_W-1:0] seq_q
);
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w && !seq_clear) |=> seq_q == $past(seq_q) + 1'b1);

  a_r10_seq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_clear && !push_w) |=> seq_q == '0);

  a_r7_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !in_ready);

  a_r6_fill_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w && !pop_w && !purge) |=> fill_w == $past(fill_w) + 1'b1);

  a_r5_fill_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_w && !push_w && !purge) |=> fill_w == $past(fill_w) - 1'b1);

  a_r9_purge_empties: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> buf_empty);

  a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && buf_empty) |=> rd_data == 32'd0);

  a_r11_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending != buf_empty);
endmodule

bind ts_readout_buf ts_buf_checker #(.CNT_W(CNT_W), .SEQ_W(ts_buf_pkg::SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .purge(purge), .seq_clear(seq_clear),
  .in_ready(in_ready), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .buf_full(buf_full), .buf_empty(buf_empty), .irq_pending(irq_pending),
  .push_w(push_w), .pop_w(pop_w), .fill_w(fill_w), .seq_q(seq_q)
);

// File: tb/ts_readout_buf_test.sv
module ts_readout_buf_test;
  localparam int DEPTH = 16;
  localparam int NVEC  = 5;
  // {seconds, cycles, fine}
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h0000_0001, 28'h000_0000, 12'h000},
    {32'hFFFF_FFFF, 28'hFFF_FFFF, 12'hFFF},
    {32'h1234_5678, 28'h773_5939, 12'h800},
    {32'h8000_0000, 28'h000_0001, 12'h001},
    {32'h0BAD_F00D, 28'h5A5_A5A5, 12'hA5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, purge = 1'b0, seq_clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_sec = '0;
  logic [27:0] in_cyc = '0;
  logic [11:0] in_fine = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid, buf_full, buf_empty, irq_pending;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int next_seq = 0;

  always #2 clk = ~clk;

  ts_readout_buf #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .purge(purge), .seq_clear(seq_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_sec(in_sec), .in_cyc(in_cyc),
    .in_fine(in_fine), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .buf_full(buf_full), .buf_empty(buf_empty),
    .irq_pending(irq_pending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] s, input logic [27:0] c, input logic [11:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_sec = s; in_cyc = c; in_fine = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    chk("R4 rd_valid", {31'd0, rd_valid}, 32'd1);
  endtask

  task automatic pop_check(input string tag, input logic [31:0] s, input logic [27:0] c,
                           input logic [11:0] f, input logic [15:0] q);
    logic [31:0] d;
    rd(2'd0, d); chk({tag, " sec"}, d, s);
    rd(2'd1, d); chk({tag, " cyc"}, d, {4'd0, c});
    rd(2'd2, d); chk({tag, " fine/seq"}, d, {q, 4'd0, f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 empty", {31'd0, buf_empty}, 32'd1);
    chk("R1 full", {31'd0, buf_full}, 32'd0);
    chk("R1 irq", {31'd0, irq_pending}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty after release", {31'd0, buf_empty}, 32'd1);
    chk("R2 ready low when disabled", {31'd0, in_ready}, 32'd0);
    enable = 1'b1;
    @(negedge clk);
    chk("R2 ready when enabled", {31'd0, in_ready}, 32'd1);

    // table walk: store all vectors, then read back in order (R3, R4, R6)
    for (int i = 0; i < NVEC; i++) push(VEC[i][71:40], VEC[i][39:12], VEC[i][11:0]);
    chk("R11 irq with entries", {31'd0, irq_pending}, 32'd1);
    rd(2'd0, d); rd(2'd1, d); rd(2'd3, d);
    chk("R4 addr3 reads zero", d, 32'd0);
    rd(2'd0, d);
    chk("R5 word0/1 reads do not pop", d, VEC[0][71:40]);
    for (int i = 0; i < NVEC; i++) begin
      pop_check("R6 table order", VEC[i][71:40], VEC[i][39:12], VEC[i][11:0], 16'(next_seq));
      next_seq++;
    end
    chk("R5 empty after pops", {31'd0, buf_empty}, 32'd1);
    chk("R11 irq cleared", {31'd0, irq_pending}, 32'd0);

    // R12: reads while empty
    rd(2'd2, d); chk("R12 empty read fine/seq", d, 32'd0);
    rd(2'd0, d); chk("R12 empty read sec", d, 32'd0);
    chk("R12 still empty", {31'd0, buf_empty}, 32'd1);

    // R7 fill to DEPTH, extra beat dropped
    for (int i = 0; i < DEPTH; i++) push(32'h1000 + i, 28'(i * 3), 12'(i + 7));
    chk("R7 full", {31'd0, buf_full}, 32'd1);
    chk("R7 ready low when full", {31'd0, in_ready}, 32'd0);
    push(32'hDEAD, 28'h1, 12'h2);
    for (int i = 0; i < DEPTH; i++) begin
      pop_check("R7 drain", 32'h1000 + i, 28'(i * 3), 12'(i + 7), 16'(next_seq));
      next_seq++;
    end
    chk("R7 empty after drain", {31'd0, buf_empty}, 32'd1);
    push(32'h77, 28'h88, 12'h99);
    pop_check("R7 seq not advanced by drop", 32'h77, 28'h88, 12'h99, 16'(next_seq));
    next_seq++;

    // R8 enable low
    enable = 1'b0;
    push(32'h55, 28'h66, 12'h44);
    chk("R8 nothing stored while disabled", {31'd0, buf_empty}, 32'd1);
    enable = 1'b1;
    push(32'h56, 28'h67, 12'h45);
    pop_check("R8 seq not advanced while disabled", 32'h56, 28'h67, 12'h45, 16'(next_seq));
    next_seq++;

    // R9 purge
    for (int i = 0; i < 3; i++) push(32'h200 + i, 28'h0, 12'h0);
    next_seq += 3;
    @(negedge clk); purge = 1'b1;
    @(negedge clk); purge = 1'b0;
    chk("R9 empty after purge", {31'd0, buf_empty}, 32'd1);
    chk("R11 irq low after purge", {31'd0, irq_pending}, 32'd0);
    push(32'h300, 28'h301, 12'h302);
    pop_check("R9 seq kept over purge", 32'h300, 28'h301, 12'h302, 16'(next_seq));
    next_seq++;
    @(negedge clk);
    purge = 1'b1; in_valid = 1'b1; in_sec = 32'h400;
    @(negedge clk);
    purge = 1'b0; in_valid = 1'b0;
    chk("R9 beat in purge cycle discarded", {31'd0, buf_empty}, 32'd1);
    push(32'h401, 28'h402, 12'h403);
    pop_check("R9 seq not advanced by discarded beat", 32'h401, 28'h402, 12'h403, 16'(next_seq));

    // R10 sequence clear
    @(negedge clk); seq_clear = 1'b1;
    @(negedge clk); seq_clear = 1'b0;
    push(32'h500, 28'h501, 12'h502);
    pop_check("R10 seq restarts at zero", 32'h500, 28'h501, 12'h502, 16'd0);
    @(negedge clk);
    seq_clear = 1'b1; in_valid = 1'b1;
    in_sec = 32'h600; in_cyc = 28'h601; in_fine = 12'h602;
    @(negedge clk);
    seq_clear = 1'b0; in_valid = 1'b0;
    push(32'h610, 28'h611, 12'h612);
    pop_check("R10 clear with store gets zero", 32'h600, 28'h601, 12'h602, 16'd0);
    pop_check("R10 next after clear gets one", 32'h610, 28'h611, 12'h612, 16'd1);

    // R3 wrap: clear, store 65535 beats while popping, then two more
    @(negedge clk); seq_clear = 1'b1;
    @(negedge clk); seq_clear = 1'b0;
    in_valid = 1'b1; in_sec = 32'h0; in_cyc = 28'h0; in_fine = 12'h0;
    rd_en = 1'b1; rd_addr = 2'd2;
    repeat (65535) @(negedge clk);
    in_valid = 1'b0; rd_en = 1'b0;
    @(negedge clk); purge = 1'b1;
    @(negedge clk); purge = 1'b0;
    push(32'hA1, 28'hA2, 12'hA3);
    push(32'hB1, 28'hB2, 12'hB3);
    pop_check("R3 last before wrap", 32'hA1, 28'hA2, 12'hA3, 16'hFFFF);
    pop_check("R3 wraps to zero", 32'hB1, 28'hB2, 12'hB3, 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule